// File: doc/BRIEF.md
# Quadrature counter channel

One counting channel for an incremental encoder. The channel takes two phase inputs and an index input, or a pulse input with a direction level on the second phase input. It keeps a 24-bit position count plus a pair of toggle flags, one for borrow and one for carry. The XOR of the two flags extends the count by one bit. Four count modes decide what happens at the ends of the range, and in two of them the preset register acts as the upper bound. An index event can reload the count from the preset.

A host drives a byte-wide register port. Writes with `bus_ctl` high are command words, and the top three bits of each word choose the target: counting mode, action command, I/O control or index control. Data-port writes fill the preset one byte at a time, and data-port reads return a count snapshot one byte at a time. Both go through one shared byte pointer that moves after each access. All encoder inputs pass through two-flop synchronizers. They are then sampled at a rate set by a prescaler, which is loaded from the low byte of the preset.

Top module: `qenc_channel`

## Requirements
- R1: After reset the count and both toggle flags are zero, the direction flag is 1, counting from the encoder inputs is disabled, index reload is disabled, the index is active high and the byte pointer is zero.
- R2: Command word 0x25 (target 001, bit 0 clears the byte pointer, bit 2 copies the live count into the output snapshot) followed by three data reads returns the snapshot least significant byte first.
- R3: In normal mode (mode word bits [2:1] = 0) an up step from 0xFFFFFF gives 0 and flips the carry toggle, and a down step from 0 gives 0xFFFFFF and flips the borrow toggle. A control-port read returns borrow toggle in bit 0, carry toggle in bit 1 and direction in bit 2, and `ext_o` is the XOR of the two toggles.
- R4: After command 0x21 clears the byte pointer, three data writes fill the preset least significant byte first. Command 0x22 copies the preset into the count, and command 0x30 clears the count and both toggles.
- R5: With function 00 (mode word bits [4:3]) each rising edge of A is one step, up when B is high and down when B is low.
- R6: With function 01 (x1) the count moves up on a rising A edge while A leads B and down on a falling A edge while B leads A. The direction flag follows the last step.
- R7: With function 10 (x2) every A edge is a step, and with function 11 (x4) every edge of A or B is a step.
- R8: In range-limit mode (2'b01) the count stops at the preset going up and at 0 going down, with no wrap.
- R9: In non-recycle mode (2'b10) the count wraps once, flips the toggle and then holds until a preset transfer or a clear.
- R10: In modulo-N mode (2'b11) an up step at the preset gives 0 and a down step at 0 gives the preset, each flipping the corresponding toggle.
- R11: Encoder steps change nothing while I/O control bit 0 (input enable) is 0.
- R12: When I/O control bit 1 is 0, an index event loads the preset into the count. Index control bit 1 sets the polarity (1 means active high). Index control bit 0 selects synchronous mode, in which the index counts only while A and B are both high. A request for synchronous mode is refused while function 00 is selected.
- R13: Command bit 3 loads the sampling prescaler from the low preset byte. Inputs are then sampled once every prescaler+1 clocks.
- R14: `evt_o` pulses for one clock on the source chosen by I/O control bits [4:3]: 00 for a carry, 01 for a step that lands on the preset, 10 for any carry or borrow, and 11 for an index event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Phase A, or count pulse |
| enc_b | input | 1 | Phase B, or direction level |
| enc_idx | input | 1 | Index input |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_ctl | input | 1 | 1 selects the command/status port, 0 the data port |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte: snapshot byte, or status when `bus_ctl` is high |
| dir_o | output | 1 | Direction of the last step, 1 for up |
| ext_o | output | 1 | Count extension bit, borrow toggle XOR carry toggle |
| evt_o | output | 1 | One-clock event pulse |

## Verification
The assertions check on every cycle the end-of-range rules: normal wrap with its carry flip, range-limit hold, modulo-N reload on underflow and the non-recycle freeze. On every cycle they also check that an index reload takes the preset, that the byte pointer clears on command and that synchronous index never coexists with pulse/direction. Only the bench scenarios can show that quadrature edge patterns give the correct number of steps per cycle in each function, that byte ordering on the port is correct, that event counts are correct per source and that the prescaler delays sampling. The bench checks these against a behavioural position model at each readback.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    typedef enum logic [1:0] {
        FN_PDIR = 2'd0,
        FN_X1   = 2'd1,
        FN_X2   = 2'd2,
        FN_X4   = 2'd3
    } func_e;

    typedef enum logic [1:0] {
        CM_NORMAL = 2'd0,
        CM_RANGE  = 2'd1,
        CM_NONREC = 2'd2,
        CM_MODN   = 2'd3
    } cmode_e;

    typedef enum logic [1:0] {
        EV_CARRY = 2'd0,
        EV_MATCH = 2'd1,
        EV_WRAP  = 2'd2,
        EV_INDEX = 2'd3
    } evsrc_e;

    // command word targets (bits [7:5])
    localparam logic [2:0] TG_MODE   = 3'd0;
    localparam logic [2:0] TG_ACTION = 3'd1;
    localparam logic [2:0] TG_IOCTL  = 3'd2;
    localparam logic [2:0] TG_IDXCTL = 3'd3;

    // action command bit positions
    localparam int ACT_BP_CLR = 0;
    localparam int ACT_XFER   = 1;
    localparam int ACT_SNAP   = 2;
    localparam int ACT_PSC    = 3;
    localparam int ACT_CLEAR  = 4;

    typedef struct packed {
        func_e  func;
        cmode_e cmode;
        logic   ab_en;
        logic   idx_ld_n;
        evsrc_e evsrc;
        logic   idx_sync;
        logic   idx_pol;
    } cfg_t;

    typedef struct packed {
        logic step;
        logic up;
        logic idx;
    } motion_t;

    // forward in x4 when the new A differs from the old B
    function automatic logic quad_up(input logic a_now, input logic b_old);
        return a_now ^ b_old;
    endfunction

endpackage

// File: rtl/qenc_sampler.sv
module qenc_sampler
    import qenc_pkg::*;
#(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic             enc_idx,
    input  logic [PSC_W-1:0] psc,
    input  logic             psc_load,
    input  func_e            func,
    input  logic             idx_sync,
    input  logic             idx_pol,
    output motion_t          mv
);
    localparam int IA = 2;
    localparam int IB = 1;
    localparam int II = 0;

    logic [2:0]       sy1, sy2, cur, prv;
    logic [PSC_W-1:0] div;
    logic             tick, fresh;

    assign tick = (div >= psc);

    always_ff @(posedge clk) begin
        if (rst) begin
            sy1   <= '0;
            sy2   <= '0;
            cur   <= '0;
            prv   <= '0;
            div   <= '0;
            fresh <= 1'b0;
        end else begin
            sy1 <= {enc_a, enc_b, enc_idx};
            sy2 <= sy1;
            if (psc_load || tick) div <= '0;
            else                  div <= div + 1'b1;
            if (tick) begin
                prv <= cur;
                cur <= sy2;
            end
            fresh <= tick && !psc_load;
        end
    end

    logic a_c, b_c, a_p, b_p, da, db;
    logic act_c, act_p, q_c, q_p;
    logic step_raw, up_raw;

    assign a_c = cur[IA];
    assign b_c = cur[IB];
    assign a_p = prv[IA];
    assign b_p = prv[IB];
    assign da  = a_c ^ a_p;
    assign db  = b_c ^ b_p;

    always_comb begin
        step_raw = 1'b0;
        up_raw   = 1'b0;
        unique case (func)
            FN_PDIR: begin
                step_raw = da & a_c;
                up_raw   = b_c;
            end
            FN_X1: begin
                up_raw   = a_c ^ b_c;
                step_raw = da & ~db & ~b_c;
            end
            FN_X2: begin
                up_raw   = a_c ^ b_c;
                step_raw = da & ~db;
            end
            FN_X4: begin
                up_raw   = quad_up(a_c, b_p);
                step_raw = da ^ db;
            end
            default: ;
        endcase
    end

    assign act_c = cur[II] ^ ~idx_pol;
    assign act_p = prv[II] ^ ~idx_pol;
    assign q_c   = act_c & (idx_sync ? (a_c & b_c) : 1'b1);
    assign q_p   = act_p & (idx_sync ? (a_p & b_p) : 1'b1);

    assign mv.step = fresh & step_raw;
    assign mv.up   = up_raw;
    assign mv.idx  = fresh & q_c & ~q_p;

endmodule

// File: rtl/qenc_core.sv
module qenc_core
    import qenc_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  cmode_e           cmode,
    input  logic             ab_en,
    input  logic             idx_ld_n,
    input  evsrc_e           evsrc,
    input  motion_t          mv,
    input  logic [CNT_W-1:0] preset,
    input  logic             ld_preset,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             borrow_t,
    output logic             carry_t,
    output logic             dir,
    output logic             evt
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic             frozen, load_idx, counting, wrap_up, wrap_dn;
    logic [CNT_W-1:0] nxt;

    assign load_idx = mv.idx & ~idx_ld_n;
    assign counting = mv.step & ab_en & ~frozen & ~clr & ~ld_preset & ~load_idx;

    always_comb begin
        nxt     = cnt;
        wrap_up = 1'b0;
        wrap_dn = 1'b0;
        if (mv.up) begin
            unique case (cmode)
                CM_NORMAL, CM_NONREC: begin
                    if (cnt == TOP) begin nxt = '0; wrap_up = 1'b1; end
                    else nxt = cnt + 1'b1;
                end
                CM_RANGE: if (cnt < preset) nxt = cnt + 1'b1;
                CM_MODN: begin
                    if (cnt >= preset) begin nxt = '0; wrap_up = 1'b1; end
                    else nxt = cnt + 1'b1;
                end
                default: ;
            endcase
        end else begin
            unique case (cmode)
                CM_NORMAL, CM_NONREC: begin
                    if (cnt == '0) begin nxt = TOP; wrap_dn = 1'b1; end
                    else nxt = cnt - 1'b1;
                end
                CM_RANGE: if (cnt != '0) nxt = cnt - 1'b1;
                CM_MODN: begin
                    if (cnt == '0) begin nxt = preset; wrap_dn = 1'b1; end
                    else nxt = cnt - 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            borrow_t <= 1'b0;
            carry_t  <= 1'b0;
            dir      <= 1'b1;
            frozen   <= 1'b0;
            evt      <= 1'b0;
        end else begin
            if (clr) begin
                cnt      <= '0;
                borrow_t <= 1'b0;
                carry_t  <= 1'b0;
                frozen   <= 1'b0;
            end else if (ld_preset || load_idx) begin
                cnt    <= preset;
                frozen <= 1'b0;
            end else if (counting) begin
                cnt      <= nxt;
                carry_t  <= carry_t ^ wrap_up;
                borrow_t <= borrow_t ^ wrap_dn;
                dir      <= mv.up;
                frozen   <= (cmode == CM_NONREC) && (wrap_up || wrap_dn);
            end
            unique case (evsrc)
                EV_CARRY: evt <= counting & wrap_up;
                EV_MATCH: evt <= counting & (nxt == preset) & (nxt != cnt);
                EV_WRAP:  evt <= counting & (wrap_up | wrap_dn);
                EV_INDEX: evt <= mv.idx;
                default:  evt <= 1'b0;
            endcase
        end
    end

    // R3: normal-mode overflow returns to zero and flips the carry toggle
    a_r3_normal_wrap: assert property (@(posedge clk) disable iff (rst)
        (counting && cmode == CM_NORMAL && mv.up && cnt == TOP)
        |=> (cnt == '0 && carry_t != $past(carry_t)));

    // R8: range-limit never passes the preset going up
    a_r8_range_hold: assert property (@(posedge clk) disable iff (rst)
        (counting && cmode == CM_RANGE && mv.up && cnt >= preset) |=> $stable(cnt));

    // R9: a frozen non-recycle count only changes through a reload
    a_r9_frozen_stable: assert property (@(posedge clk) disable iff (rst)
        (frozen && !clr && !ld_preset && !load_idx) |=> $stable(cnt));

    // R10: modulo-N underflow reloads the preset
    a_r10_modn_under: assert property (@(posedge clk) disable iff (rst)
        (counting && cmode == CM_MODN && !mv.up && cnt == '0) |=> (cnt == $past(preset)));

    // R12: an enabled index event loads the preset
    a_r12_index_load: assert property (@(posedge clk) disable iff (rst)
        (load_idx && !clr) |=> (cnt == $past(preset)));

endmodule

// File: rtl/qenc_regfile.sv
module qenc_regfile
    import qenc_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic             bus_ctl,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic [CNT_W-1:0] cnt,
    input  logic             borrow_t,
    input  logic             carry_t,
    input  logic             dir,
    output cfg_t             cfg,
    output logic [CNT_W-1:0] preset,
    output logic [PSC_W-1:0] psc,
    output logic             psc_load,
    output logic             ld_preset,
    output logic             clr
);
    localparam int NB   = CNT_W / 8;
    localparam int BP_W = (NB > 1) ? $clog2(NB) : 1;
    localparam logic [BP_W-1:0] BP_LAST = BP_W'(NB - 1);

    logic [NB-1:0][7:0] pre_b, snap_b;
    logic [BP_W-1:0]    bp;
    logic               wr_cmd, wr_dat, rd_dat, act;
    logic [2:0]         tgt;

    assign tgt    = bus_wdata[7:5];
    assign wr_cmd = bus_wr & bus_ctl;
    assign wr_dat = bus_wr & ~bus_ctl;
    assign rd_dat = bus_rd & ~bus_ctl;
    assign act    = wr_cmd && (tgt == TG_ACTION);

    assign ld_preset = act & bus_wdata[ACT_XFER];
    assign clr       = act & bus_wdata[ACT_CLEAR];
    assign psc_load  = act & bus_wdata[ACT_PSC];
    assign preset    = pre_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '{func: FN_PDIR, cmode: CM_NORMAL, ab_en: 1'b0, idx_ld_n: 1'b1,
                        evsrc: EV_CARRY, idx_sync: 1'b0, idx_pol: 1'b1};
            bp     <= '0;
            pre_b  <= '0;
            snap_b <= '0;
            psc    <= '0;
        end else if (wr_cmd) begin
            unique case (tgt)
                TG_MODE: begin
                    cfg.func  <= func_e'(bus_wdata[4:3]);
                    cfg.cmode <= cmode_e'(bus_wdata[2:1]);
                    if (bus_wdata[4:3] == 2'd0) cfg.idx_sync <= 1'b0;
                end
                TG_ACTION: begin
                    if (bus_wdata[ACT_BP_CLR]) bp <= '0;
                    if (bus_wdata[ACT_SNAP])   snap_b <= cnt;
                    if (bus_wdata[ACT_PSC])    psc <= pre_b[0][PSC_W-1:0];
                end
                TG_IOCTL: begin
                    cfg.ab_en    <= bus_wdata[0];
                    cfg.idx_ld_n <= bus_wdata[1];
                    cfg.evsrc    <= evsrc_e'(bus_wdata[4:3]);
                end
                TG_IDXCTL: begin
                    cfg.idx_sync <= bus_wdata[0] && (cfg.func != FN_PDIR);
                    cfg.idx_pol  <= bus_wdata[1];
                end
                default: ;
            endcase
        end else if (wr_dat) begin
            pre_b[bp] <= bus_wdata;
            if (bp != BP_LAST) bp <= bp + 1'b1;
        end else if (rd_dat) begin
            if (bp != BP_LAST) bp <= bp + 1'b1;
        end
    end

    assign bus_rdata = bus_ctl ? {5'b0, dir, carry_t, borrow_t} : snap_b[bp];

    // R2: clearing the byte pointer takes effect on the next cycle
    a_r2_bp_clear: assert property (@(posedge clk) disable iff (rst)
        (act && bus_wdata[ACT_BP_CLR]) |=> (bp == '0));

    // R12: synchronous index never coexists with pulse/direction
    a_r12_sync_quad: assert property (@(posedge clk) disable iff (rst)
        cfg.idx_sync |-> (cfg.func != FN_PDIR));

endmodule

// File: rtl/qenc_channel.sv
module qenc_channel
    import qenc_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int PSC_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enc_a,
    input  logic       enc_b,
    input  logic       enc_idx,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic       bus_ctl,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       dir_o,
    output logic       ext_o,
    output logic       evt_o
);
    cfg_t             cfg;
    motion_t          mv;
    logic [CNT_W-1:0] cnt, preset;
    logic [PSC_W-1:0] psc;
    logic             psc_load, ld_preset, clr, borrow_t, carry_t;

    qenc_regfile #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_ctl(bus_ctl),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt(cnt), .borrow_t(borrow_t),
        .carry_t(carry_t), .dir(dir_o), .cfg(cfg), .preset(preset), .psc(psc),
        .psc_load(psc_load), .ld_preset(ld_preset), .clr(clr)
    );

    qenc_sampler #(.PSC_W(PSC_W)) u_samp (
        .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
        .psc(psc), .psc_load(psc_load), .func(cfg.func), .idx_sync(cfg.idx_sync),
        .idx_pol(cfg.idx_pol), .mv(mv)
    );

    qenc_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst(rst), .cmode(cfg.cmode), .ab_en(cfg.ab_en),
        .idx_ld_n(cfg.idx_ld_n), .evsrc(cfg.evsrc), .mv(mv), .preset(preset),
        .ld_preset(ld_preset), .clr(clr), .cnt(cnt), .borrow_t(borrow_t),
        .carry_t(carry_t), .dir(dir_o), .evt(evt_o)
    );

    assign ext_o = borrow_t ^ carry_t;

endmodule

// File: tb/qenc_channel_tb.sv
`timescale 1ns/1ps
module qenc_channel_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_ctl = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       dir_o, ext_o, evt_o;

    int checks = 0, fails = 0, evt_cnt = 0;
    bit done = 0;

    // behavioural position model
    int m_cnt = 0, m_pre = 0, m_mode = 0, m_fn = 0;
    bit m_bt = 0, m_ct = 0, m_dir = 1, m_frz = 0;
    bit qa = 0, qb = 0;

    always #2.5 clk = ~clk;

    qenc_channel u_dut (
        .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_ctl(bus_ctl), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .dir_o(dir_o), .ext_o(ext_o), .evt_o(evt_o)
    );

    always @(negedge clk) if (!rst && evt_o) evt_cnt++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic wr_cmd(input logic [7:0] v);
        @(negedge clk); bus_ctl = 1'b1; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic wr_dat(input logic [7:0] v);
        @(negedge clk); bus_ctl = 1'b0; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd_byte(input bit ctl, output logic [7:0] v);
        @(negedge clk); bus_ctl = ctl; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic read_count(output int v);
        logic [7:0] b0, b1, b2;
        wr_cmd(8'h25);
        rd_byte(1'b0, b0); rd_byte(1'b0, b1); rd_byte(1'b0, b2);
        v = int'({b2, b1, b0});
    endtask

    task automatic chk_state(input string req);
        int v;
        logic [7:0] s;
        read_count(v);
        check(req, v, m_cnt);
        rd_byte(1'b1, s);
        check(req, int'(s), int'({5'b0, m_dir, m_ct, m_bt}));
        check(req, int'(ext_o), int'(m_bt ^ m_ct));
    endtask

    task automatic set_preset(input int v);
        wr_cmd(8'h21);
        wr_dat(v[7:0]); wr_dat(v[15:8]); wr_dat(v[23:16]);
        m_pre = v & 32'hFFFFFF;
    endtask

    task automatic set_mode(input int fn, input int cm);
        wr_cmd({3'b000, fn[1:0], cm[1:0], 1'b0});
        m_fn = fn; m_mode = cm;
    endtask

    task automatic xfer();  wr_cmd(8'h22); m_cnt = m_pre; m_frz = 0; endtask
    task automatic clear(); wr_cmd(8'h30); m_cnt = 0; m_bt = 0; m_ct = 0; m_frz = 0; endtask

    task automatic mstep(input bit up);
        if (m_frz) return;
        m_dir = up;
        case (m_mode)
            1: begin
                if (up) begin if (m_cnt < m_pre) m_cnt++; end
                else if (m_cnt > 0) m_cnt--;
            end
            3: begin
                if (up) begin
                    if (m_cnt >= m_pre) begin m_cnt = 0; m_ct ^= 1; end else m_cnt++;
                end else begin
                    if (m_cnt == 0) begin m_cnt = m_pre; m_bt ^= 1; end else m_cnt--;
                end
            end
            default: begin
                if (up) begin
                    if (m_cnt == 32'hFFFFFF) begin m_cnt = 0; m_ct ^= 1; m_frz = (m_mode == 2); end
                    else m_cnt++;
                end else begin
                    if (m_cnt == 0) begin m_cnt = 32'hFFFFFF; m_bt ^= 1; m_frz = (m_mode == 2); end
                    else m_cnt--;
                end
            end
        endcase
    endtask

    task automatic set_ab(input bit a, input bit b);
        @(negedge clk); enc_a = a; enc_b = b; qa = a; qb = b;
        cyc(6);
    endtask

    task automatic pulse_a(input bit up, input bit counts);
        set_ab(1'b0, up);
        set_ab(1'b1, up);
        if (counts) mstep(up);
        set_ab(1'b0, up);
    endtask

    task automatic qmove(input bit fwd, input int n);
        for (int i = 0; i < n; i++) begin
            bit na, nb, hit;
            na = fwd ? ~qb : qb;
            nb = fwd ? qa : ~qa;
            hit = (m_fn == 3) || (m_fn == 2 && na != qa) ||
                  (m_fn == 1 && na != qa && (fwd ? na : ~na));
            set_ab(na, nb);
            if (hit) mstep(fwd);
        end
    endtask

    task automatic idx_pulse();
        @(negedge clk); enc_idx = 1'b1; cyc(6);
        @(negedge clk); enc_idx = 1'b0; cyc(6);
    endtask

    task automatic park();
        wr_cmd(8'h42);
        set_ab(1'b0, 1'b0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R0 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int v;
        logic [7:0] s;
        cyc(3);
        @(negedge clk); rst = 1'b0;
        cyc(2);

        // R1: reset state
        read_count(v); check("R1 count", v, 0);
        rd_byte(1'b1, s); check("R1 status", int'(s), 32'h04);
        check("R1 ext", int'(ext_o), 0);

        // R11: inputs disabled at reset, steps ignored
        pulse_a(1'b1, 1'b0); pulse_a(1'b1, 1'b0);
        chk_state("R11 disabled");

        // R5: pulse/direction
        set_mode(0, 0); wr_cmd(8'h43);
        for (int i = 0; i < 5; i++) pulse_a(1'b1, 1'b1);
        chk_state("R5 up");
        for (int i = 0; i < 2; i++) pulse_a(1'b0, 1'b1);
        chk_state("R5 down");
        set_ab(1'b0, 1'b0);

        // R6: x1
        set_mode(1, 0);
        qmove(1'b1, 12); chk_state("R6 x1 fwd");
        qmove(1'b0, 4);  chk_state("R6 x1 back");

        // R7: x2 and x4
        set_mode(2, 0);
        qmove(1'b1, 8); chk_state("R7 x2");
        set_mode(3, 0);
        qmove(1'b1, 8); qmove(1'b0, 4); chk_state("R7 x4");

        // R4 / R3 / R14: preset transfer, wrap both ways, carry event
        set_preset(32'hFFFFFE); xfer();
        chk_state("R4 transfer");
        evt_cnt = 0;
        qmove(1'b1, 4); chk_state("R3 carry wrap");
        qmove(1'b0, 3); chk_state("R3 borrow wrap");
        check("R14 carry events", evt_cnt, 1);

        // R8: range-limit
        clear(); set_mode(3, 1); set_preset(5);
        qmove(1'b1, 8); chk_state("R8 top hold");
        qmove(1'b0, 7); chk_state("R8 bottom hold");

        // R10 / R14: modulo-N with match events
        clear(); set_mode(3, 3); wr_cmd(8'h4B);
        evt_cnt = 0;
        qmove(1'b1, 7); chk_state("R10 up wrap");
        qmove(1'b0, 3); chk_state("R10 down wrap");
        check("R14 match events", evt_cnt, 2);

        // R9 / R14: non-recycle with wrap events
        set_mode(3, 2); wr_cmd(8'h53);
        set_preset(32'hFFFFFD); xfer();
        evt_cnt = 0;
        qmove(1'b1, 5); chk_state("R9 frozen");
        check("R14 wrap events", evt_cnt, 1);
        xfer(); qmove(1'b1, 1); chk_state("R9 reload resumes");

        // R12: index reload, disabled reload, sync rules
        park();
        set_mode(0, 0); clear();
        wr_cmd(8'h41); set_preset(32'h123456); wr_cmd(8'h62);
        idx_pulse(); m_cnt = m_pre;
        chk_state("R12 index load");
        wr_cmd(8'h5B);
        pulse_a(1'b1, 1'b1);
        evt_cnt = 0;
        idx_pulse(); chk_state("R12 load disabled");
        check("R14 index event", evt_cnt, 1);
        set_ab(1'b0, 1'b0);
        wr_cmd(8'h63); wr_cmd(8'h41);
        idx_pulse(); m_cnt = m_pre;
        chk_state("R12 sync refused in pulse mode");
        set_mode(3, 0); wr_cmd(8'h63); clear();
        idx_pulse(); chk_state("R12 sync needs A and B high");
        wr_cmd(8'h62);

        // R13: prescaler
        set_mode(0, 0); wr_cmd(8'h43); clear();
        set_preset(200); wr_cmd(8'h28);
        set_ab(1'b1, 1'b1);
        cyc(10);
        read_count(v); check("R13 before slow sample", v, 0);
        cyc(250);
        mstep(1'b1);
        read_count(v); check("R13 after slow sample", v, m_cnt);

        done = 1;
        summary();
        $finish;
    end
endmodule